// File: doc/BRIEF.md
# Operand Alignment Shifter

This block sits in the operand path between a 16-bit data bus and a 32-bit arithmetic unit. It places a 16-bit memory word inside a 32-bit field. The word is shifted left by 0 to 16 places. Zeros fill the vacated low bits. The bits above the shifted word are either zeros or copies of the word's sign bit. The block is purely combinational, so the aligned word reaches the arithmetic unit in the same cycle as the data. No pipeline stage is added.

Each operation picks where its shift count comes from. One source is a 5-bit constant carried in the instruction. The other is a temporary register value that software can change at run time. A fixed count suits alignment at a known point in the code. A register count lets a scaling factor adapt while the system runs. Scaled arithmetic and the placement of masks for logical operations both use this alignment.

Top module: `input_scaler`

## Requirements
- R1: With the instruction source selected and a count of 0, `data_o[15:0]` equals `data_i`. With `sext_i` = 0, `data_o[31:16]` is zero in that case.
- R2: The effective count is n. Bits `data_o[n-1:0]` are zero and bits `data_o[n+15:n]` equal `data_i`.
- R3: Sign fill is on (`sext_i` = 1) and `data_i[15]` = 1. Every bit of `data_o` above position n+15 is 1.
- R4: Sign fill is off (`sext_i` = 0). Every bit of `data_o` above position n+15 is 0, whatever the sign of `data_i`. This also holds when sign fill is on and `data_i[15]` = 0.
- R5: `cnt_src_i` = 0 selects the instruction field `imm_cnt_i` as the count. Values 0 to 16 are used as given.
- R6: `cnt_src_i` = 1 selects the temporary register. Only `treg_i[3:0]` is used, which gives 0 to 15. `treg_i[15:4]` has no effect on `data_o`.
- R7: An instruction-field count above 16 (17 to 31) behaves exactly like a count of 16.
- R8: A shift of 16 places `data_i` in `data_o[31:16]` and zeros in `data_o[15:0]`. This holds with sign fill on or off.
- R9: `data_o` depends only on the present inputs. It changes within the same cycle as the inputs, with no register on the path.
- R10: The count source that is not selected has no effect on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 16 | Data word from the bus |
| sext_i | input | 1 | 1: sign fill above the word, 0: zero fill |
| cnt_src_i | input | 1 | 0: instruction count, 1: temporary register count |
| imm_cnt_i | input | 5 | Shift count carried in the instruction |
| treg_i | input | 16 | Temporary register value; low 4 bits give the count |
| data_o | output | 32 | Aligned 32-bit word |

## Verification
The bound checker tests several properties on every input change. It checks that the zero-count case passes the word through (R1). It checks that bit 0 is set only for an unshifted odd word (R2). It checks the polarity of the top bit under the register source, for both sign fill and zero fill (R3, R4). It also checks that an instruction count of 16 or more gives the half-word move (R7, R8). Other behaviours show up only through the bench scenarios, which compare each output with an independently computed expected word. These are the mask of the exact fill region at each count, the fact that the upper register bits and the unselected source are ignored, and the same-cycle response.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int unsigned DIN_W   = 16;
  localparam int unsigned DOUT_W  = 32;
  localparam int unsigned CNT_W   = 5;
  localparam int unsigned MAX_SH  = 16;
  localparam int unsigned TREG_CW = 4;

  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_TREG  = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/scaler_count_sel.sv
module scaler_count_sel #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned TREG_W  = 16,
  parameter int unsigned TREG_CW = 4,
  parameter int unsigned MAX_SH  = 16
) (
  input  logic              src_treg_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [TREG_W-1:0] treg_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SH);

  logic [CNT_W-1:0] imm_clamped;
  logic [CNT_W-1:0] treg_cnt;

  // instruction field saturates at the maximum shift
  always_comb begin
    if (imm_cnt_i > MAX_CNT) imm_clamped = MAX_CNT;
    else                     imm_clamped = imm_cnt_i;
  end

  assign treg_cnt = CNT_W'(treg_i[TREG_CW-1:0]);
  assign cnt_o    = src_treg_i ? treg_cnt : imm_clamped;
endmodule

// File: rtl/scaler_shift_core.sv
module scaler_shift_core #(
  parameter int unsigned DIN_W  = 16,
  parameter int unsigned DOUT_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [DIN_W-1:0]  data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DOUT_W-1:0] data_o
);
  logic [DOUT_W-1:0] stage [CNT_W+1];

  assign stage[0] = DOUT_W'(data_i);

  // logarithmic stages, one per count bit
  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    always_comb begin
      if (cnt_i[s]) stage[s+1] = {stage[s][DOUT_W-1-STEP:0], {STEP{1'b0}}};
      else          stage[s+1] = stage[s];
    end
  end

  assign data_o = stage[CNT_W];
endmodule

// File: rtl/scaler_fill_mask.sv
module scaler_fill_mask #(
  parameter int unsigned DIN_W  = 16,
  parameter int unsigned DOUT_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DOUT_W-1:0] mask_o
);
  localparam int unsigned LIM_W = CNT_W + 2;

  logic [LIM_W-1:0] top_pos;

  assign top_pos = LIM_W'(cnt_i) + LIM_W'(DIN_W);

  // bit b is fill when it lies at or above cnt + DIN_W
  for (genvar b = 0; b < DOUT_W; b++) begin : g_bit
    assign mask_o[b] = (LIM_W'(b) >= top_pos);
  end
endmodule

// File: rtl/input_scaler.sv
module input_scaler
  import scaler_pkg::*;
(
  input  logic [DIN_W-1:0]  data_i,
  input  logic              sext_i,
  input  logic              cnt_src_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [DIN_W-1:0]  treg_i,
  output logic [DOUT_W-1:0] data_o
);
  logic [CNT_W-1:0]  eff_cnt;
  logic [DOUT_W-1:0] shifted;
  logic [DOUT_W-1:0] fill_mask;
  logic              fill_on;

  scaler_count_sel #(
    .CNT_W  (CNT_W),
    .TREG_W (DIN_W),
    .TREG_CW(TREG_CW),
    .MAX_SH (MAX_SH)
  ) i_count_sel (
    .src_treg_i(cnt_src_i == SRC_TREG),
    .imm_cnt_i (imm_cnt_i),
    .treg_i    (treg_i),
    .cnt_o     (eff_cnt)
  );

  scaler_shift_core #(
    .DIN_W (DIN_W),
    .DOUT_W(DOUT_W),
    .CNT_W (CNT_W)
  ) i_shift_core (
    .data_i(data_i),
    .cnt_i (eff_cnt),
    .data_o(shifted)
  );

  scaler_fill_mask #(
    .DIN_W (DIN_W),
    .DOUT_W(DOUT_W),
    .CNT_W (CNT_W)
  ) i_fill_mask (
    .cnt_i (eff_cnt),
    .mask_o(fill_mask)
  );

  assign fill_on = sext_i & data_i[DIN_W-1];
  assign data_o  = shifted | (fill_on ? fill_mask : '0);
endmodule

// File: rtl/input_scaler_chk.sv
module input_scaler_chk
  import scaler_pkg::*;
(
  input logic [DIN_W-1:0]  data_i,
  input logic              sext_i,
  input logic              cnt_src_i,
  input logic [CNT_W-1:0]  imm_cnt_i,
  input logic [DIN_W-1:0]  treg_i,
  input logic [DOUT_W-1:0] data_o
);
  logic known;
  assign known = !$isunknown({data_i, sext_i, cnt_src_i, imm_cnt_i, treg_i, data_o});

  always_comb begin
    if (known) begin
      // R1
      pass_through_chk: assert (!(cnt_src_i == SRC_INSTR && imm_cnt_i == '0)
                                || data_o[DIN_W-1:0] == data_i);
      // R2
      lsb_chk: assert (data_o[0] == (data_i[0] &&
                       (cnt_src_i == SRC_TREG ? treg_i[TREG_CW-1:0] == '0
                                              : imm_cnt_i == '0)));
      // R3
      sign_fill_chk: assert (!(cnt_src_i == SRC_TREG && sext_i && data_i[DIN_W-1])
                             || data_o[DOUT_W-1]);
      // R4
      zero_fill_chk: assert (!(cnt_src_i == SRC_TREG && !sext_i) || !data_o[DOUT_W-1]);
      // R7 R8
      half_move_chk: assert (!(cnt_src_i == SRC_INSTR && imm_cnt_i >= CNT_W'(MAX_SH))
                             || data_o == {data_i, {DIN_W{1'b0}}});
    end
  end
endmodule

bind input_scaler input_scaler_chk i_input_scaler_chk (
  .data_i   (data_i),
  .sext_i   (sext_i),
  .cnt_src_i(cnt_src_i),
  .imm_cnt_i(imm_cnt_i),
  .treg_i   (treg_i),
  .data_o   (data_o)
);

// File: tb/test_input_scaler.sv
module test_input_scaler;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        sext_i = 1'b0;
  logic        cnt_src_i = 1'b0;
  logic [4:0]  imm_cnt_i = '0;
  logic [15:0] treg_i = '0;
  logic [31:0] data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  input_scaler i_input_scaler (
    .data_i   (data_i),
    .sext_i   (sext_i),
    .cnt_src_i(cnt_src_i),
    .imm_cnt_i(imm_cnt_i),
    .treg_i   (treg_i),
    .data_o   (data_o)
  );

  function automatic logic [31:0] model(logic [15:0] d, logic sx, logic src,
                                        logic [4:0] imm, logic [15:0] tr);
    int n;
    logic [31:0] ext;
    n   = src ? int'(tr[3:0]) : ((int'(imm) > 16) ? 16 : int'(imm));
    ext = sx ? {{16{d[15]}}, d} : {16'h0, d};
    return ext << n;
  endfunction

  task automatic drive(logic [15:0] d, logic sx, logic src, logic [4:0] imm,
                       logic [15:0] tr, string req);
    item_t it;
    @(negedge clk);
    data_i = d; sext_i = sx; cnt_src_i = src; imm_cnt_i = imm; treg_i = tr;
    it.exp = model(d, sx, src, imm, tr);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: same-cycle result (R9), sampled one ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          failures++;
          $display("FAIL %s: got %h expected %h", it.req, data_o, it.exp);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (data_o !== 32'h0) begin
      failures++;
      $display("FAIL reset: got %h expected %h", data_o, 32'h0);
    end
    rst_ni = 1'b1;

    drive(16'h8001, 1'b0, 1'b0, 5'd0,  16'h0, "R1 pass-through zero fill");
    drive(16'h8001, 1'b1, 1'b0, 5'd0,  16'h0, "R1 R3 pass-through sign fill");
    drive(16'hA5C3, 1'b0, 1'b0, 5'd5,  16'h0, "R2 R5 instr count 5");
    drive(16'hA5C3, 1'b1, 1'b0, 5'd7,  16'h0, "R3 R5 sign fill count 7");
    drive(16'h7FFF, 1'b1, 1'b0, 5'd3,  16'h0, "R4 positive sign fill");
    drive(16'hFFFF, 1'b0, 1'b0, 5'd9,  16'h0, "R4 zero fill negative");
    drive(16'h1234, 1'b1, 1'b0, 5'd16, 16'h0, "R8 shift 16 positive");
    drive(16'h8765, 1'b1, 1'b0, 5'd16, 16'h0, "R8 shift 16 sign on");
    drive(16'h8765, 1'b1, 1'b0, 5'd17, 16'h0, "R7 clamp 17");
    drive(16'hC001, 1'b0, 1'b0, 5'd31, 16'h0, "R7 clamp 31");
    drive(16'h9ABC, 1'b1, 1'b1, 5'd2,  16'hFFF3, "R6 treg low bits 3");
    drive(16'h9ABC, 1'b1, 1'b1, 5'd2,  16'h0003, "R6 treg upper bits ignored");
    drive(16'h8000, 1'b1, 1'b1, 5'd0,  16'h000F, "R6 R3 treg max 15");
    drive(16'h8000, 1'b0, 1'b1, 5'd0,  16'h0010, "R6 treg 16 reads as 0");
    drive(16'h00F0, 1'b0, 1'b1, 5'd31, 16'h0004, "R10 imm ignored under treg");
    drive(16'h00F0, 1'b0, 1'b0, 5'd4,  16'hFFFF, "R10 treg ignored under imm");
    for (int k = 0; k <= 16; k++)
      drive(16'hB00D, 1'b1, 1'b0, 5'(k), 16'h0, "R2 R5 count sweep");
    for (int k = 0; k < 16; k++)
      drive(16'h4C21 ^ 16'(k), 1'b0, 1'b1, 5'd0, 16'(k), "R2 R6 treg sweep");

    @(posedge clk);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule